// File: doc/BRIEF.md
# DS3 Path Data-Link Message Receiver

This block collects path maintenance messages from the DS3 overhead data link. An upstream framer marks the few data-link bit positions in each M-frame with a one-cycle strobe. The block takes only those bits. It hunts for the 0x7E delimiter and removes the zeros the sender inserted for transparency. It drops frames cut short by an abort and checks the 16-bit frame check sequence. Message bytes go into a small on-chip buffer that the host reads one byte at a time, in the order they arrived.

The block does not filter on the address byte, so standard and non-standard message formats are accepted alike. A good message raises a ready flag and an interrupt, and it latches the message length (frame check bytes excluded). The buffer then belongs to the host until the host pulses the clear input. Any message that completes in the meantime is counted as lost and leaves the buffer untouched.

The serial input is a valid-qualified stream with no ready signal. The framer cannot pause the line, so the block accepts a bit on every cycle in which `dl_valid` is high, including back-to-back cycles. It cannot exert back-pressure and never needs to. Host reads and clears are single-cycle pulses.

Top module: `dl_lapd_rx`

## Requirements
- R1: A bit on `dl_bit` is taken only in a cycle with `dl_valid` high; whatever `dl_bit` carries in other cycles changes no output.
- R2: The pattern 0x7E (six 1s between two 0s) opens and closes a frame. Consecutive delimiters with no data between them are idle and produce no status change.
- R3: Inside a frame, a 0 that follows five consecutive 1s is removed before byte assembly, so payload bytes of 0xFF and 0x7E come through unchanged.
- R4: Seven or more consecutive 1s abort the frame in progress. It is discarded with no status, and the next delimiter starts reception again.
- R5: The frame check sequence is a CRC-16 with polynomial x^16+x^12+x^5+1, preset to all ones, sent least significant bit first and ones-complemented. A frame whose register after its last bit is not 0xF0B8 sets the sticky `fcs_err` and does not raise `msg_ready`.
- R6: An octet-aligned frame of 4 to 82 bytes (frame check bytes excluded) with a correct check sets `msg_ready` and `irq`, and loads `msg_len` with that byte count. Any address value is accepted. `msg_ready` and `msg_len` hold until `host_clr`.
- R7: A frame with more than 82 bytes (frame check bytes excluded) sets the sticky `overrun` and is discarded.
- R8: A frame of fewer than 4 bytes (frame check bytes excluded) is discarded with no status.
- R9: A frame whose bit count at the closing delimiter is not a multiple of 8 is discarded with no status.
- R10: A good message that completes while `msg_ready` is high, or that began while it was high, sets `lost`. It leaves `msg_len` and the buffer contents unchanged.
- R11: Message bytes are stored from offset 0 in arrival order, and the first received bit of each byte is its bit 0. `host_data` shows the byte at the read pointer, and a `host_rd` pulse advances the pointer by one.
- R12: A `host_clr` pulse clears `msg_ready`, `irq`, `fcs_err`, `overrun` and `lost`, and returns the read pointer to offset 0. After reset all status outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dl_bit | input | 1 | Data-link bit from the framer |
| dl_valid | input | 1 | Marks a cycle that carries a data-link bit |
| host_rd | input | 1 | Advance the buffer read pointer by one byte |
| host_clr | input | 1 | Release the buffer, clear status, rewind the read pointer |
| host_data | output | 8 | Buffer byte at the read pointer |
| msg_ready | output | 1 | A good message is waiting in the buffer |
| msg_len | output | 7 | Length of the waiting message in bytes, check bytes excluded |
| fcs_err | output | 1 | Sticky: a frame failed the check |
| overrun | output | 1 | Sticky: a frame exceeded the maximum length |
| lost | output | 1 | Sticky: a good message was dropped while the buffer was held |
| irq | output | 1 | Interrupt request, high while a message waits |

## Verification
A wrong internal state shows up only at the next closing delimiter, because that is the one moment the block reports anything. Each case below affects the ports at that point.
- A slipped hold-back line or ones counter mis-destuffs or misframes the frame. It then shows either a wrong `msg_len` with wrong bytes, or a spurious `fcs_err`.
- A stuck buffer hold shows up as a missing `lost` on the second message, or as overwritten bytes.
- A read pointer that is not rewound shows on the very first `host_data` after the next clear.

The length sweep covers every accepted size, so an off-by-one at either size limit surfaces on the first frame that crosses it.

// File: rtl/dl_lapd_pkg.sv
package dl_lapd_pkg;
  localparam int FCS_BYTES = 2;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_LE = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;

  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;

  typedef struct packed {
    logic flag;
    logic abort;
    logic commit;
    logic cbit;
  } bit_evt_t;
endpackage

// File: rtl/dl_lapd_bitproc.sv
module dl_lapd_bitproc
  import dl_lapd_pkg::*;
#(
  parameter int RUN_FLAG = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_bit,
  input  logic     in_valid,
  input  logic     hunting,
  output bit_evt_t evt
);
  localparam int HOLD = RUN_FLAG + 1;
  localparam int RW   = $clog2(RUN_FLAG + 2);
  localparam int HW   = $clog2(HOLD + 1);

  logic [RW-1:0]   ones;
  logic [HOLD-1:0] hold;
  logic [HW-1:0]   fill;
  logic is_flag, is_abort, is_stuff, push;

  always_comb begin
    is_flag    = in_valid && !in_bit && (ones == RW'(RUN_FLAG));
    is_abort   = in_valid && in_bit && (ones >= RW'(RUN_FLAG));
    is_stuff   = in_valid && !in_bit && (ones == RW'(RUN_FLAG - 1));
    push       = in_valid && !hunting && !is_flag && !is_abort && !is_stuff;
    evt.flag   = is_flag;
    evt.abort  = is_abort;
    evt.commit = push && (fill == HW'(HOLD));
    evt.cbit   = hold[HOLD-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ones <= '0;
    end else if (in_valid) begin
      if (!in_bit)                      ones <= '0;
      else if (ones != RW'(RUN_FLAG+1)) ones <= ones + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= '0;
      fill <= '0;
    end else if (is_flag || is_abort) begin
      fill <= '0;
    end else if (push) begin
      hold <= {hold[HOLD-2:0], in_bit};
      if (fill != HW'(HOLD)) fill <= fill + 1'b1;
    end
  end
endmodule

// File: rtl/dl_lapd_crc.sv
module dl_lapd_crc
  import dl_lapd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        din,
  output logic [15:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= CRC_PRESET;
    else if (en)       crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ din) ? CRC_POLY_LE : 16'h0000);
  end
endmodule

// File: rtl/dl_lapd_buf.sv
module dl_lapd_buf #(
  parameter  int DEPTH = 90,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          rd_adv,
  input  logic          rd_rst,
  output logic [7:0]    rd_data
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] rd_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rd_rst)                     rd_ptr <= '0;
    else if (rd_adv && rd_ptr != AW'(DEPTH-1)) rd_ptr <= rd_ptr + 1'b1;
  end

  assign rd_data = mem[rd_ptr];
endmodule

// File: rtl/dl_lapd_rx.sv
module dl_lapd_rx
  import dl_lapd_pkg::*;
#(
  parameter  int BUF_DEPTH = 90,
  parameter  int MAX_MSG   = 82,
  parameter  int MIN_MSG   = 4,
  localparam int CNT_W     = $clog2(MAX_MSG + FCS_BYTES + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dl_bit,
  input  logic             dl_valid,
  input  logic             host_rd,
  input  logic             host_clr,
  output logic [7:0]       host_data,
  output logic             msg_ready,
  output logic [CNT_W-1:0] msg_len,
  output logic             fcs_err,
  output logic             overrun,
  output logic             lost,
  output logic             irq
);
  localparam int AW = $clog2(BUF_DEPTH);

  rx_state_e        st;
  bit_evt_t         ev;
  logic [7:0]       sr;
  logic [2:0]       nbit;
  logic [CNT_W-1:0] nbyte;
  logic             wr_ok;
  logic [15:0]      crc;
  logic [7:0]       byte_val;
  logic byte_done, too_long, close, sized_ok, good, fcs_bad;
  logic set_ready, set_lost, ready_nx;

  dl_lapd_bitproc #(.RUN_FLAG(6)) u_bits (
    .clk(clk), .rst_n(rst_n), .in_bit(dl_bit), .in_valid(dl_valid),
    .hunting(st == ST_HUNT), .evt(ev)
  );

  dl_lapd_crc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(ev.flag), .en(ev.commit),
    .din(ev.cbit), .crc_q(crc)
  );

  dl_lapd_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(byte_done && wr_ok),
    .wr_addr(AW'(nbyte)), .wr_data(byte_val),
    .rd_adv(host_rd), .rd_rst(host_clr), .rd_data(host_data)
  );

  always_comb begin
    byte_val  = {ev.cbit, sr[7:1]};
    byte_done = ev.commit && (nbit == 3'd7);
    too_long  = byte_done && (nbyte == CNT_W'(MAX_MSG + FCS_BYTES));
    close     = ev.flag && (st == ST_FRAME);
    sized_ok  = (nbit == 3'd0) && (nbyte >= CNT_W'(MIN_MSG + FCS_BYTES));
    good      = close && sized_ok && (crc == CRC_RESIDUE);
    fcs_bad   = close && sized_ok && (crc != CRC_RESIDUE);
    set_ready = good && wr_ok;
    set_lost  = good && !wr_ok;
    ready_nx  = (msg_ready && !host_clr) || set_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_HUNT;
      sr    <= '0;
      nbit  <= '0;
      nbyte <= '0;
      wr_ok <= 1'b0;
    end else if (ev.flag) begin
      st    <= ST_FRAME;
      nbit  <= '0;
      nbyte <= '0;
      wr_ok <= !ready_nx;
    end else if (ev.abort || too_long) begin
      st <= ST_HUNT;
    end else if (ev.commit) begin
      sr   <= byte_val;
      nbit <= nbit + 1'b1;
      if (byte_done) nbyte <= nbyte + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_ready <= 1'b0;
      msg_len   <= '0;
      fcs_err   <= 1'b0;
      overrun   <= 1'b0;
      lost      <= 1'b0;
    end else begin
      msg_ready <= ready_nx;
      if (set_ready) msg_len <= nbyte - CNT_W'(FCS_BYTES);
      fcs_err <= (fcs_err && !host_clr) || fcs_bad;
      overrun <= (overrun && !host_clr) || too_long;
      lost    <= (lost && !host_clr) || set_lost;
    end
  end

  assign irq = msg_ready;
endmodule

// File: rtl/dl_lapd_rx_chk.sv
module dl_lapd_rx_chk #(
  parameter int CNT_W   = 7,
  parameter int MAX_MSG = 82,
  parameter int MIN_MSG = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dl_valid,
  input logic             host_clr,
  input logic             msg_ready,
  input logic [CNT_W-1:0] msg_len,
  input logic             fcs_err,
  input logic             overrun,
  input logic             lost
);
  assert_ready_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready && !host_clr |=> msg_ready && $stable(msg_len));

  assert_len_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_ready) |-> (msg_len >= CNT_W'(MIN_MSG)) && (msg_len <= CNT_W'(MAX_MSG)));

  assert_fcs_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fcs_err && !host_clr |=> fcs_err);

  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !host_clr |=> overrun);

  assert_lost_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lost && !host_clr |=> lost);

  assert_no_strobe_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_valid && !host_clr |=> $stable({msg_ready, msg_len, fcs_err, overrun, lost}));

  assert_clear_wipes_R12: assert property (@(posedge clk) disable iff (!rst_n)
    host_clr && !dl_valid |=> !msg_ready && !fcs_err && !overrun && !lost);
endmodule

bind dl_lapd_rx dl_lapd_rx_chk #(.CNT_W(CNT_W), .MAX_MSG(MAX_MSG), .MIN_MSG(MIN_MSG)) u_chk (
  .clk(clk), .rst_n(rst_n), .dl_valid(dl_valid), .host_clr(host_clr),
  .msg_ready(msg_ready), .msg_len(msg_len), .fcs_err(fcs_err),
  .overrun(overrun), .lost(lost)
);

// File: tb/tb_dl_lapd_rx.sv
module tb_dl_lapd_rx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0, dl_bit = 1'b1, dl_valid = 1'b0, host_rd = 1'b0, host_clr = 1'b0;
  logic [7:0] host_data;
  logic [6:0] msg_len;
  logic       msg_ready, fcs_err, overrun, lost, irq;

  dl_lapd_rx dut (
    .clk(clk), .rst_n(rst_n), .dl_bit(dl_bit), .dl_valid(dl_valid),
    .host_rd(host_rd), .host_clr(host_clr), .host_data(host_data),
    .msg_ready(msg_ready), .msg_len(msg_len), .fcs_err(fcs_err),
    .overrun(overrun), .lost(lost), .irq(irq)
  );

  int checks = 0, errors = 0, ones = 0;
  logic [15:0] crc;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int seed);
    if (seed == 999) return 8'hFF;
    if (i == 1) return 8'hFF;
    if (i == 2) return 8'h7E;
    return 8'((i * 37 + seed * 11 + 3) & 255);
  endfunction

  // one strobed bit, then one unstrobed cycle carrying the opposite value
  task automatic raw_bit(input logic b);
    @(negedge clk); dl_valid = 1'b1; dl_bit = b;
    @(negedge clk); dl_valid = 1'b0; dl_bit = ~b;
  endtask

  task automatic data_bit(input logic b);
    raw_bit(b);
    if (b) begin
      ones++;
      if (ones == 5) begin raw_bit(1'b0); ones = 0; end
    end else ones = 0;
  endtask

  task automatic send_flag();
    for (int k = 0; k < 8; k++) raw_bit((k == 0 || k == 7) ? 1'b0 : 1'b1);
    ones = 0;
  endtask

  task automatic crc_bit(input logic b);
    logic fb;
    fb  = crc[0] ^ b;
    crc = crc >> 1;
    if (fb) crc = crc ^ 16'h8408;
  endtask

  task automatic send_frame(input int n, input int seed, input bit bad, input int extra);
    logic [15:0] fcs;
    send_flag();
    crc = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      logic [7:0] v;
      v = pat(i, seed);
      for (int k = 0; k < 8; k++) begin crc_bit(v[k]); data_bit(v[k]); end
    end
    fcs = ~crc;
    if (bad) fcs[0] = ~fcs[0];
    for (int k = 0; k < 16; k++) data_bit(fcs[k]);
    for (int k = 0; k < extra; k++) data_bit(k[0]);
    send_flag();
  endtask

  task automatic expect_status(input string req, input int rdy, input int len, input int fe, input int ov, input int lo);
    chk(msg_ready == rdy, req, "msg_ready", int'(msg_ready), rdy);
    chk(irq == rdy, req, "irq", int'(irq), rdy);
    if (rdy != 0) chk(msg_len == len, req, "msg_len", int'(msg_len), len);
    chk(fcs_err == fe, req, "fcs_err", int'(fcs_err), fe);
    chk(overrun == ov, req, "overrun", int'(overrun), ov);
    chk(lost == lo, req, "lost", int'(lost), lo);
  endtask

  task automatic read_check(input int n, input int seed, input string req);
    int bad_at = -1;
    logic [7:0] got = 8'h00;
    for (int i = 0; i < n; i++) begin
      if (bad_at < 0 && host_data != pat(i, seed)) begin bad_at = i; got = host_data; end
      host_rd = 1'b1;
      @(negedge clk); host_rd = 1'b0;
    end
    if (bad_at < 0) chk(1'b1, req, "buffer bytes", 0, 0);
    else chk(1'b0, req, $sformatf("buffer byte %0d", bad_at), int'(got), int'(pat(bad_at, seed)));
  endtask

  task automatic host_clear();
    @(negedge clk); host_clr = 1'b1;
    @(negedge clk); host_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..R12 actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_status("R12 reset", 0, 0, 0, 0, 0);

    // R2: idle delimiters only
    for (int i = 0; i < 6; i++) send_flag();
    expect_status("R2 idle flags", 0, 0, 0, 0, 0);

    // R1: delimiter and frame patterns offered without the strobe
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); dl_valid = 1'b0; dl_bit = ((i % 8) == 0) ? 1'b0 : 1'b1;
    end
    expect_status("R1 unstrobed bits", 0, 0, 0, 0, 0);

    // R6 R11 R12: every accepted length
    for (int n = 4; n <= 82; n++) begin
      send_frame(n, n, 1'b0, 0);
      expect_status("R6 length sweep", 1, n, 0, 0, 0);
      read_check(n, n, "R11 byte order");
      host_clear();
      expect_status("R12 clear", 0, 0, 0, 0, 0);
    end

    // R3: all-ones payload relies on zero deletion
    send_frame(6, 999, 1'b0, 0);
    expect_status("R3 all ones payload", 1, 6, 0, 0, 0);
    read_check(6, 999, "R3 destuffed bytes");
    host_clear();

    // R8: short frames
    send_frame(3, 7, 1'b0, 0);
    send_frame(1, 8, 1'b0, 0);
    expect_status("R8 short frames", 0, 0, 0, 0, 0);

    // R7: one byte over the limit
    send_frame(83, 9, 1'b0, 0);
    expect_status("R7 overrun", 0, 0, 0, 1, 0);
    host_clear();

    // R5: corrupted check
    send_frame(10, 10, 1'b1, 0);
    expect_status("R5 bad fcs", 0, 0, 1, 0, 0);
    host_clear();

    // R9: three stray bits before closing delimiter
    send_frame(8, 11, 1'b0, 3);
    expect_status("R9 not octet aligned", 0, 0, 0, 0, 0);

    // R4: abort in mid frame, then a good frame
    send_flag();
    for (int i = 0; i < 5; i++) for (int k = 0; k < 8; k++) data_bit(pat(i, 12)[k]);
    for (int k = 0; k < 8; k++) raw_bit(1'b1);
    send_flag();
    expect_status("R4 aborted frame", 0, 0, 0, 0, 0);
    send_frame(6, 13, 1'b0, 0);
    expect_status("R4 after abort", 1, 6, 0, 0, 0);
    read_check(6, 13, "R4 bytes after abort");
    host_clear();

    // R10: second message while first is held
    send_frame(12, 100, 1'b0, 0);
    send_frame(20, 200, 1'b0, 0);
    expect_status("R10 lost message", 1, 12, 0, 0, 1);
    read_check(12, 100, "R10 buffer kept");
    host_clear();
    expect_status("R12 clear after lost", 0, 0, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule